// File: doc/BRIEF.md
# Pointer-Windowed Clock and Alarm Register Interface

This block sits between a processor bus and a calendar timekeeper with its alarm comparator. It exposes seven clock fields and six alarm fields through two 16-bit windows. Each window has a 2-bit pointer that picks a high:low field pair. After each access the pointer moves down by one, so software can walk all pairs with back-to-back accesses. The counters live outside the block. For each field the block emits a one-cycle write strobe, and the counter takes the new byte from the matching byte of `bus_wdata`. On a read the block returns the counter's current value with the unimplemented bits cleared.

Writes to the clock fields and to the clock run bit are refused unless a write-enable bit is set. That bit can only be set through a short timed key. The bytes 0x55 and 0xAA go to the key register on consecutive cycles, and the set must land in the very next cycle. Clearing the bit needs no key. The alarm fields are not locked.

Top module: `rtc_regwin`

Register addresses: 0 config, 1 alarm config, 2 clock window, 3 alarm window, 4 key. In the config register, bit 15 is the run bit, bit 13 is write-enable and bits 9:8 are the clock pointer. In the alarm config register, bits 9:8 are the alarm pointer. `bus_rdata` is combinational and valid while `bus_rd` is high.

## Requirements
- R1: After reset, write-enable, the run bit and both pointers are 0, and both config registers read 0x0000.
- R2: In the clock window, the pointer selects a pair of fields (high byte:low byte). Pointer 0 gives minutes:seconds, 1 gives weekday:hours, 2 gives month:day, and 3 gives zero:year. On a read each field is masked to its implemented bits: seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, day 0x3F, month 0x1F, year 0xFF.
- R3: In the alarm window, pointer 0 gives minutes:seconds, 1 gives weekday:hours and 2 gives month:day, with the same masks. Pointer 3 reads 0x0000 and a write there raises no strobe.
- R4: A window pointer moves down by one on any read of its window, and on a write with byte enable 1 (high byte). It stays at 0 once it reaches 0. A write with only byte enable 0 does not move it.
- R5: A write of the high byte of either config register loads that window's pointer from bits 9:8.
- R6: A clock window write strobes `tk_we` (bit order: seconds, minutes, hours, weekday, day, month, year, LSB first), one bit per enabled byte, only while write-enable is 1. Alarm window writes strobe `al_we` (same order without year) regardless of write-enable.
- R7: A write of the run bit (bit 15) takes effect only if write-enable was already 1 before that write.
- R8: Write-enable becomes 1 only in this sequence: 0x55 is written to the key register's low byte, 0xAA in the next cycle, and then a config write with bit 13 set in the cycle after that. A fresh 0x55 always restarts the sequence.
- R9: Any other bus write in the sequence, a different key byte, or an idle cycle before the set attempt returns the unlock logic to idle, and write-enable stays 0.
- R10: A config high-byte write with bit 13 clear sets write-enable to 0 on the next cycle, with no key.
- R11: Unimplemented bits read as 0. This covers config bits other than 15, 13, 9 and 8, alarm config bits other than 9:8, the key register, and addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request (always 16 bits) |
| bus_be | input | 2 | Byte enables for writes (bit 1 = high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during `bus_rd` |
| tk_vals | input | 56 | Clock field values, seconds in bits 7:0 up to year in bits 55:48 |
| tk_we | output | 7 | Clock field write strobes |
| al_vals | input | 48 | Alarm field values, seconds in bits 7:0 up to month in bits 47:40 |
| al_we | output | 6 | Alarm field write strobes |
| run_en | output | 1 | Clock run bit |
| wr_en | output | 1 | Write-enable bit |

## Verification
A pointer that steps wrongly shows up at the first read of the following window access: the bench then sees the wrong field pair, or reads back the wrong pointer from a config register. Faults in the unlock state machine never move write-enable on their own. They only appear one cycle later, either as a strobe missing from `tk_we` or as a config read that disagrees on bits 13 and 15. Each bench sequence therefore ends with a config read or a strobe observation that follows its last write directly.

// File: rtl/rtc_regwin.sv
module rtc_regwin #(
  parameter int          AW         = 3,
  parameter logic [7:0]  KEY_FIRST  = 8'h55,
  parameter logic [7:0]  KEY_SECOND = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_be,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic [55:0]   tk_vals,
  output logic [6:0]    tk_we,
  input  logic [47:0]   al_vals,
  output logic [5:0]    al_we,
  output logic          run_en,
  output logic          wr_en
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_ALCFG = AW'(1);
  localparam logic [AW-1:0] A_CWIN  = AW'(2);
  localparam logic [AW-1:0] A_AWIN  = AW'(3);
  localparam logic [AW-1:0] A_KEY   = AW'(4);
  localparam logic [55:0]   FLD_MASK = {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F};

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_t;

  logic [1:0] cptr, aptr;
  key_t       kst, kst_nx;
  logic [7:0] c_hi, c_lo, a_hi, a_lo;

  wire wr_hi       = bus_wr & bus_be[1];
  wire wr_lo       = bus_wr & bus_be[0];
  wire ctrl_hi_wr  = wr_hi && bus_addr == A_CTRL;
  wire alcfg_hi_wr = wr_hi && bus_addr == A_ALCFG;
  wire key_wr      = wr_lo && bus_addr == A_KEY;
  wire c_acc       = bus_addr == A_CWIN && (wr_hi || (bus_rd && !bus_wr));
  wire a_acc       = bus_addr == A_AWIN && (wr_hi || (bus_rd && !bus_wr));

  function automatic logic [7:0] fld(input logic [55:0] v, input logic [2:0] i);
    fld = v[i*8 +: 8] & FLD_MASK[i*8 +: 8];
  endfunction

  always_comb begin
    c_lo = fld(tk_vals, {cptr, 1'b0});
    c_hi = (cptr == 2'd3) ? 8'h00 : fld(tk_vals, {cptr, 1'b1});
    a_lo = (aptr == 2'd3) ? 8'h00 : fld({8'h00, al_vals}, {aptr, 1'b0});
    a_hi = (aptr == 2'd3) ? 8'h00 : fld({8'h00, al_vals}, {aptr, 1'b1});
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {run_en, 1'b0, wr_en, 3'b000, cptr, 8'h00};
        A_ALCFG: bus_rdata = {6'b0, aptr, 8'h00};
        A_CWIN:  bus_rdata = {c_hi, c_lo};
        A_AWIN:  bus_rdata = {a_hi, a_lo};
        default: bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    tk_we = '0;
    al_we = '0;
    if (wr_en && bus_addr == A_CWIN) begin
      if (wr_lo)                  tk_we[{cptr, 1'b0}] = 1'b1;
      if (wr_hi && cptr != 2'd3)  tk_we[{cptr, 1'b1}] = 1'b1;
    end
    if (bus_addr == A_AWIN && aptr != 2'd3) begin
      if (wr_lo) al_we[{aptr, 1'b0}] = 1'b1;
      if (wr_hi) al_we[{aptr, 1'b1}] = 1'b1;
    end
  end

  always_comb begin
    kst_nx = K_IDLE;
    if (key_wr) begin
      if (bus_wdata[7:0] == KEY_FIRST)                         kst_nx = K_HALF;
      else if (bus_wdata[7:0] == KEY_SECOND && kst == K_HALF)  kst_nx = K_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cptr   <= '0;
      aptr   <= '0;
      run_en <= 1'b0;
      wr_en  <= 1'b0;
      kst    <= K_IDLE;
    end else begin
      kst <= kst_nx;
      if (ctrl_hi_wr) begin
        cptr <= bus_wdata[9:8];
        if (wr_en) run_en <= bus_wdata[15];
        if (!bus_wdata[13])      wr_en <= 1'b0;
        else if (kst == K_ARMED) wr_en <= 1'b1;
      end else if (c_acc && cptr != 2'd0) begin
        cptr <= cptr - 2'd1;
      end
      if (alcfg_hi_wr)                  aptr <= bus_wdata[9:8];
      else if (a_acc && aptr != 2'd0)   aptr <= aptr - 2'd1;
    end
  end

  // R4
  cptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !ctrl_hi_wr && cptr != 2'd0) |=> cptr == $past(cptr) - 2'd1);
  // R4
  aptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aptr == 2'd0 && !alcfg_hi_wr) |=> aptr == 2'd0);
  // R8
  wren_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(kst) == K_ARMED);
  // R7
  run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hi_wr && !wr_en) |=> $stable(run_en));
  // R10
  wren_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hi_wr && !bus_wdata[13]) |=> !wr_en);
  // R6
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tk_we) <= 2 && $countones(al_we) <= 2);
  // R11
  key_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_KEY) |-> bus_rdata == 16'h0000);
endmodule

// File: tb/rtc_regwin_tb.sv
module rtc_regwin_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [55:0] tk_vals = {8'h99, 8'hF2, 8'hF1, 8'hFE, 8'hE3, 8'hC7, 8'hD8};
  logic [47:0] al_vals = {8'h31, 8'h27, 8'h0B, 8'h45, 8'h92, 8'h81};
  logic [6:0]  tk_we;
  logic [5:0]  al_we;
  logic        run_en, wr_en;
  logic        chk = 1'b0;
  logic        done = 1'b0;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regwin u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tk_vals(tk_vals), .tk_we(tk_we), .al_vals(al_vals), .al_we(al_we),
    .run_en(run_en), .wr_en(wr_en)
  );

  localparam logic [2:0] CTRL = 3'd0, ALCFG = 3'd1, CWIN = 3'd2, AWIN = 3'd3, KEY = 3'd4;

  task automatic op(input logic wr, input logic rd, input logic [2:0] a, input logic [1:0] be,
                    input logic [15:0] d, input logic c, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_be = be; bus_wdata = d; chk = c;
    if (c) begin exp_q.push_back(e); tag_q.push_back(t); end
  endtask
  task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    op(1'b1, 1'b0, a, be, d, 1'b0, 16'h0, "");
  endtask
  task automatic wr_obs(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d,
                        input logic [15:0] e, input string t);
    op(1'b1, 1'b0, a, be, d, 1'b1, e, t);
  endtask
  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    op(1'b0, 1'b1, a, 2'b00, 16'h0, 1'b1, e, t);
  endtask
  task automatic idle();
    op(1'b0, 1'b0, 3'd0, 2'b00, 16'h0, 1'b0, 16'h0, "");
  endtask

  // monitor: pops one expected item per flagged cycle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (chk && exp_q.size() > 0) begin
        logic [15:0] obs, e;
        string t;
        obs = bus_rd ? bus_rdata : {3'b000, al_we, tk_we};
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (obs !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, obs, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(CTRL,  16'h0000, "R1 config after reset");
    rd(ALCFG, 16'h0000, "R1 alarm config after reset");
    rd(CWIN,  16'h4758, "R2 clock ptr0 min:sec");
    rd(CTRL,  16'h0000, "R4 clock ptr saturates at 0");
    wr(CTRL, 2'b10, 16'h0300);
    rd(CWIN,  16'h0099, "R2 clock ptr3 zero:year");
    rd(CWIN,  16'h1231, "R2 clock ptr2 month:day");
    rd(CWIN,  16'h0623, "R2 clock ptr1 weekday:hours");
    rd(CWIN,  16'h4758, "R4 walk down to ptr0");
    rd(CTRL,  16'h0000, "R4 ptr held at 0");
    wr(CTRL, 2'b10, 16'h0200);
    wr_obs(CWIN, 2'b01, 16'h1111, 16'h0000, "R6 locked low write no strobe");
    rd(CTRL,  16'h0200, "R5 R4 ptr loaded, low-only write no step");
    wr(CTRL, 2'b10, 16'h8200);
    rd(CTRL,  16'h0200, "R7 run write refused while locked");
    wr(KEY, 2'b01, 16'h0055);
    wr(KEY, 2'b01, 16'h00AA);
    wr(CTRL, 2'b10, 16'h2200);
    rd(CTRL,  16'h2200, "R8 key sequence sets write-enable");
    wr_obs(CWIN, 2'b11, 16'h0515, 16'h0030, "R6 unlocked word write month+day");
    wr_obs(CWIN, 2'b01, 16'h0012, 16'h0004, "R6 unlocked low write hours");
    wr_obs(CWIN, 2'b10, 16'h0300, 16'h0008, "R6 unlocked high write weekday");
    rd(CTRL,  16'h2000, "R4 steps on word/high writes only");
    wr(CTRL, 2'b10, 16'hA000);
    rd(CTRL,  16'hA000, "R7 run write accepted when unlocked");
    wr(CTRL, 2'b10, 16'h8000);
    rd(CTRL,  16'h8000, "R10 write-enable cleared without key");
    wr_obs(CWIN, 2'b11, 16'h1234, 16'h0000, "R6 relocked word write no strobe");
    wr(ALCFG, 2'b10, 16'h0300);
    rd(ALCFG, 16'h0300, "R5 alarm pointer load");
    rd(AWIN,  16'h0000, "R3 alarm ptr3 reads zero");
    rd(AWIN,  16'h1127, "R3 alarm ptr2 month:day");
    rd(AWIN,  16'h0305, "R3 alarm ptr1 weekday:hours");
    rd(AWIN,  16'h1201, "R3 alarm ptr0 min:sec");
    wr(ALCFG, 2'b10, 16'h0100);
    wr_obs(AWIN, 2'b11, 16'h0407, 16'h0600, "R6 alarm write unlocked");
    wr(ALCFG, 2'b10, 16'h0300);
    wr_obs(AWIN, 2'b11, 16'hFFFF, 16'h0000, "R3 alarm ptr3 write no strobe");
    rd(ALCFG, 16'h0200, "R4 alarm ptr stepped on high write");
    wr(KEY, 2'b01, 16'h0055);
    wr(KEY, 2'b01, 16'h0012);
    wr(KEY, 2'b01, 16'h00AA);
    wr(CTRL, 2'b10, 16'h2000);
    rd(CTRL,  16'h8000, "R9 broken key leaves write-enable 0");
    wr(KEY, 2'b01, 16'h0055);
    wr(KEY, 2'b01, 16'h00AA);
    idle();
    wr(CTRL, 2'b10, 16'h2000);
    rd(CTRL,  16'h8000, "R9 late set attempt refused");
    wr(KEY, 2'b01, 16'h0055);
    wr(KEY, 2'b01, 16'h0055);
    wr(KEY, 2'b01, 16'h00AA);
    wr(CTRL, 2'b10, 16'h2000);
    rd(CTRL,  16'hA000, "R8 repeated first key restarts sequence");
    rd(KEY,   16'h0000, "R11 key register reads zero");
    rd(3'd5,  16'h0000, "R11 unmapped address reads zero");
    idle();
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule